// File: doc/BRIEF.md
# Two-Wire Target Address Front End with Sub-Block Routing

This block sits behind the pins of a two-wire serial target. It brings SCL and SDA into the system clock domain and finds the START and STOP conditions. It shifts in the first byte after each START and decides whether that byte names this device. If it does, the block acknowledges the byte. It then raises a one-hot select to one of three internal targets: a memory array, a control/status register, or a potentiometer register bank. It also reports whether the transaction is a read or a write.

For a write, each later byte is acknowledged and handed downstream with a one-cycle strobe. For the memory array and the potentiometer bank, this happens only while the write-enable latch input is set. The control/status register takes writes regardless of the latch.

A byte that is not acknowledged ends data transfer. After that, only a STOP or a new START brings the front end back into step with the bus. The internal targets, nonvolatile storage and command parsing all live downstream.

Top module: `i2cs_subsel_top`

## Requirements
- R1: A STOP (SDA rising while SCL is high, seen on the synchronized lines) clears the select and the direction output and returns the block to waiting for a START.
- R2: The address byte is acknowledged only when its bits [7:4] equal 4'b1010 and its bit 3 equals the strap input; otherwise no acknowledge is driven and the select stays all-zero.
- R3: On an acknowledged address, bits [2:1] choose the select: 00 raises sel_o[0] (memory array), 10 raises sel_o[1] (control/status), 11 raises sel_o[2] (potentiometer bank); the select is one-hot and is held until the next START or STOP.
- R4: Address bits [2:1] = 01 are reserved: the byte is not acknowledged, no select is raised, and the block waits for a START.
- R5: rd_o takes address bit 0 of an acknowledged address (1 = read, 0 = write); after a read address no further acknowledge is driven by the block.
- R6: The acknowledge pull is asserted from the SCL falling edge after the eighth bit until the next SCL falling edge, and is off during the eighth bit's SCL high phase and after the ninth clock.
- R7: In a write to the control/status register, or to the memory array or potentiometer bank while wel_i is 1 at the end of the byte, each data byte is acknowledged and presented on wr_data_o with a single-cycle wr_stb_o.
- R8: A data byte for the memory array or potentiometer bank while wel_i is 0 is not acknowledged and not strobed, and later bytes are ignored until a START or STOP, even if wel_i rises.
- R9: A START arriving in the middle of a byte clears the select at once and restarts address reception, so that a following address byte is decoded afresh.
- R10: After reset the acknowledge pull, select, direction and strobe outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired with the block's own pull) |
| a0_strap_i | input | 1 | Board strap compared with address bit 3 |
| wel_i | input | 1 | Write-enable latch level for memory array and potentiometer writes |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| sel_o | output | 3 | One-hot target select: [0] memory, [1] control/status, [2] potentiometer |
| rd_o | output | 1 | Direction of the selected transaction, 1 = read |
| wr_stb_o | output | 1 | One-cycle strobe for an accepted write data byte |
| wr_data_o | output | 8 | Accepted write data byte |

## Verification
All 256 address byte values are swept with the strap at both levels. This separates the type-code check, the strap comparison, the reserved route code and each of the three select encodings from one another, and it checks the direction bit on every match.

Directed write sequences to each target, with the latch set and clear, show where latch gating applies and where it does not. A latch that rises after a rejected byte shows that the rejection sticks. A START issued three bits into a data byte, followed by a new address, shows that the selection is dropped and decoding restarts. Acknowledge samples taken during the eighth bit, the ninth bit and after it bound the pull window.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W  = 8;
    localparam int N_TGT   = 3;
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    localparam int TGT_MEM = 0;
    localparam int TGT_CSR = 1;
    localparam int TGT_POT = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_DATA,
        ST_DACK
    } eng_st_e;

    typedef struct packed {
        eng_st_e             st;
        logic [BYTE_W-1:0]   sh;
        logic [CNT_W-1:0]    cnt;
        logic                drv;
        logic [N_TGT-1:0]    sel;
        logic                rd;
        logic                stb;
        logic [BYTE_W-1:0]   dat;
    } eng_s;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] synced;
    logic [N_LINES-1:0] prev_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= synced;
    end

    // index 0 = SCL, index 1 = SDA
    assign scl_rise  =  synced[0] & ~prev_q[0];
    assign scl_fall  = ~synced[0] &  prev_q[0];
    assign sda_s     =  synced[1];
    assign start_det =  synced[0] &  prev_q[0] &  prev_q[1] & ~synced[1];
    assign stop_det  =  synced[0] &  prev_q[0] & ~prev_q[1] &  synced[1];

endmodule

// File: rtl/i2cs_addr_decode.sv
module i2cs_addr_decode
    import i2cs_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE = 4'b1010
) (
    input  logic [BYTE_W-1:0] addr,
    input  logic              strap,
    output logic              hit,
    output logic [N_TGT-1:0]  sel,
    output logic              rd
);
    logic type_ok;
    logic strap_ok;

    assign type_ok  = (addr[7:4] == DEV_TYPE);
    assign strap_ok = (addr[3] == strap);
    assign rd       = addr[0];

    always_comb begin
        sel = '0;
        unique case (addr[2:1])
            2'b00:   sel[TGT_MEM] = 1'b1;
            2'b10:   sel[TGT_CSR] = 1'b1;
            2'b11:   sel[TGT_POT] = 1'b1;
            default: sel = '0;
        endcase
    end

    assign hit = type_ok & strap_ok & (|sel);

endmodule

// File: rtl/i2cs_byte_engine.sv
module i2cs_byte_engine
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              wel_i,
    input  logic              dec_hit,
    input  logic [N_TGT-1:0]  dec_sel,
    input  logic              dec_rd,
    output logic [BYTE_W-1:0] shift_o,
    output logic              drv_o,
    output logic [N_TGT-1:0]  sel_o,
    output logic              rd_o,
    output logic              stb_o,
    output logic [BYTE_W-1:0] dat_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    eng_s r_q, r_d;
    logic wr_allow;

    // the control/status register ignores the write-enable latch
    assign wr_allow = r_q.sel[TGT_CSR] | wel_i;

    always_comb begin
        r_d     = r_q;
        r_d.stb = 1'b0;
        if (start_det) begin
            r_d.st  = ST_ADDR;
            r_d.cnt = '0;
            r_d.sel = '0;
            r_d.rd  = 1'b0;
            r_d.drv = 1'b0;
        end else if (stop_det) begin
            r_d.st  = ST_IDLE;
            r_d.cnt = '0;
            r_d.sel = '0;
            r_d.rd  = 1'b0;
            r_d.drv = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_ADDR, ST_DATA: begin
                    if (scl_rise && r_q.cnt != LAST) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_s};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == LAST) begin
                        if (r_q.st == ST_ADDR) begin
                            if (dec_hit) begin
                                r_d.drv = 1'b1;
                                r_d.sel = dec_sel;
                                r_d.rd  = dec_rd;
                                r_d.st  = ST_AACK;
                            end else begin
                                r_d.st  = ST_IDLE;
                            end
                        end else begin
                            if (wr_allow) begin
                                r_d.drv = 1'b1;
                                r_d.stb = 1'b1;
                                r_d.dat = r_q.sh;
                                r_d.st  = ST_DACK;
                            end else begin
                                r_d.st  = ST_IDLE;
                            end
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        r_d.drv = 1'b0;
                        r_d.cnt = '0;
                        r_d.st  = r_q.rd ? ST_IDLE : ST_DATA;
                    end
                end
                ST_DACK: begin
                    if (scl_fall) begin
                        r_d.drv = 1'b0;
                        r_d.cnt = '0;
                        r_d.st  = ST_DATA;
                    end
                end
                default: r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.sh  <= '0;
            r_q.cnt <= '0;
            r_q.drv <= 1'b0;
            r_q.sel <= '0;
            r_q.rd  <= 1'b0;
            r_q.stb <= 1'b0;
            r_q.dat <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign shift_o = r_q.sh;
    assign drv_o   = r_q.drv;
    assign sel_o   = r_q.sel;
    assign rd_o    = r_q.rd;
    assign stb_o   = r_q.stb;
    assign dat_o   = r_q.dat;

endmodule

// File: rtl/i2cs_subsel_top.sv
module i2cs_subsel_top
    import i2cs_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              a0_strap_i,
    input  logic              wel_i,
    output logic              sda_pull_o,
    output logic [N_TGT-1:0]  sel_o,
    output logic              rd_o,
    output logic              wr_stb_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    logic              scl_rise, scl_fall, sda_s, start_det, stop_det;
    logic [BYTE_W-1:0] shift_byte;
    logic              dec_hit, dec_rd;
    logic [N_TGT-1:0]  dec_sel;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cs_addr_decode #(.DEV_TYPE(DEV_TYPE)) u_dec (
        .addr  (shift_byte),
        .strap (a0_strap_i),
        .hit   (dec_hit),
        .sel   (dec_sel),
        .rd    (dec_rd)
    );

    i2cs_byte_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .wel_i     (wel_i),
        .dec_hit   (dec_hit),
        .dec_sel   (dec_sel),
        .dec_rd    (dec_rd),
        .shift_o   (shift_byte),
        .drv_o     (sda_pull_o),
        .sel_o     (sel_o),
        .rd_o      (rd_o),
        .stb_o     (wr_stb_o),
        .dat_o     (wr_data_o)
    );

endmodule

// File: rtl/i2cs_subsel_chk.sv
module i2cs_subsel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic [2:0] sel,
    input logic       rd,
    input logic       drv,
    input logic       stb
);
    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    p_stop_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (sel == 3'b000 && !rd));

    p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (sel == 3'b000));

    p_sel_with_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel) == 3'b000 && sel != 3'b000) |-> drv);

    p_pull_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drv) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    p_stb_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> (sel != 3'b000 && !rd && drv));

    p_stb_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);

endmodule

bind i2cs_subsel_top i2cs_subsel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sel       (sel_o),
    .rd        (rd_o),
    .drv       (sda_pull_o),
    .stb       (wr_stb_o)
);

// File: tb/tb_i2cs_subsel_top.sv
module tb_i2cs_subsel_top;
    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b0;
    logic       wel = 1'b0;
    logic       sda_line;
    logic       sda_pull;
    logic [2:0] sel;
    logic       rd;
    logic       stb;
    logic [7:0] wdat;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    logic [7:0] last_dat = '0;
    logic drv_b8 = 1'b0;
    logic drv_ack = 1'b0;
    logic drv_post = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2cs_subsel_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .a0_strap_i (strap),
        .wel_i      (wel),
        .sda_pull_o (sda_pull),
        .sel_o      (sel),
        .rd_o       (rd),
        .wr_stb_o   (stb),
        .wr_data_o  (wdat)
    );

    always @(negedge clk) begin
        if (stb) begin
            stb_cnt  <= stb_cnt + 1;
            last_dat <= wdat;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(Q);
            if (i == 0) drv_b8 = sda_pull;
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        drv_ack = sda_pull;
        acked = ~sda_line;
        scl_m = 1'b0; wq(Q);
        drv_post = sda_pull;
    endtask

    function automatic logic [2:0] exp_sel(input logic [7:0] a, input logic s);
        if (a[7:4] != 4'hA || a[3] != s) return 3'b000;
        case (a[2:1])
            2'b00:   return 3'b001;
            2'b10:   return 3'b010;
            2'b11:   return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic ack;
        logic [2:0] es;
        int n0;
        wq(4);
        // R10 reset state
        chk("R10 pull", sda_pull, 0);
        chk("R10 sel", sel, 0);
        chk("R10 rd", rd, 0);
        chk("R10 stb", stb, 0);
        rst_n = 1'b1;
        wq(4);

        // R2 R3 R4 R5 sweep over every address byte and both strap levels
        for (int s = 0; s < 2; s++) begin
            strap = s[0];
            for (int a = 0; a < 256; a++) begin
                es = exp_sel(a[7:0], strap);
                bus_start();
                send_byte(a[7:0], ack);
                chk("R2 ack", ack, (es != 3'b000));
                chk("R3 sel", sel, es);
                if (a[2:1] == 2'b01) chk("R4 reserved", ack, 0);
                if (es != 3'b000) chk("R5 rd", rd, a[0]);
                bus_stop();
                if (es != 3'b000) chk("R1 stop clears", sel, 0);
            end
        end
        strap = 1'b0;

        // R6 acknowledge window on a matching write address
        bus_start();
        send_byte(8'hA0, ack);
        chk("R6 pull off bit8", drv_b8, 0);
        chk("R6 pull on bit9", drv_ack, 1);
        chk("R6 pull off after", drv_post, 0);
        // R7 memory write with latch set
        wel = 1'b1;
        n0 = stb_cnt;
        send_byte(8'h5A, ack);
        chk("R7 mem ack", ack, 1);
        chk("R7 mem stb", stb_cnt - n0, 1);
        chk("R7 mem data", last_dat, 8'h5A);
        send_byte(8'hC3, ack);
        chk("R7 mem 2nd data", last_dat, 8'hC3);
        chk("R7 mem 2nd stb", stb_cnt - n0, 2);
        bus_stop();

        // R8 memory write with latch clear, latch rises before next byte
        wel = 1'b0;
        bus_start();
        send_byte(8'hA0, ack);
        chk("R8 addr ack", ack, 1);
        n0 = stb_cnt;
        send_byte(8'h11, ack);
        chk("R8 no ack", ack, 0);
        chk("R8 no stb", stb_cnt - n0, 0);
        wel = 1'b1;
        send_byte(8'h22, ack);
        chk("R8 stays ignored", ack, 0);
        chk("R8 stays no stb", stb_cnt - n0, 0);
        chk("R8 sel kept", sel, 3'b001);
        bus_stop();

        // R7 control/status write ignores latch
        wel = 1'b0;
        bus_start();
        send_byte(8'hA4, ack);
        n0 = stb_cnt;
        send_byte(8'h96, ack);
        chk("R7 csr ack", ack, 1);
        chk("R7 csr data", last_dat, 8'h96);
        chk("R7 csr stb", stb_cnt - n0, 1);
        bus_stop();

        // R7 potentiometer write with latch, R8 without
        wel = 1'b1;
        bus_start();
        send_byte(8'hA6, ack);
        n0 = stb_cnt;
        send_byte(8'h3C, ack);
        chk("R7 pot data", last_dat, 8'h3C);
        chk("R7 pot stb", stb_cnt - n0, 1);
        bus_stop();
        wel = 1'b0;
        bus_start();
        send_byte(8'hA6, ack);
        n0 = stb_cnt;
        send_byte(8'h3C, ack);
        chk("R8 pot no ack", ack, 0);
        chk("R8 pot no stb", stb_cnt - n0, 0);
        bus_stop();

        // R5 read: no acknowledge after the address byte
        bus_start();
        send_byte(8'hA1, ack);
        chk("R5 read rd", rd, 1);
        send_byte(8'hFF, ack);
        chk("R5 no ack in read", drv_ack, 0);
        bus_stop();

        // R9 repeated START three bits into a data byte
        wel = 1'b1;
        bus_start();
        send_byte(8'hA6, ack);
        chk("R9 first sel", sel, 3'b100);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        bus_start();
        chk("R9 sel cleared", sel, 0);
        send_byte(8'hA5, ack);
        chk("R9 new ack", ack, 1);
        chk("R9 new sel", sel, 3'b010);
        chk("R9 new rd", rd, 1);
        bus_stop();
        chk("R1 idle after stop", sel, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule